// File: doc/BRIEF.md
# I2C Target with Host-Paced Clock Stretching

This block is a 7-bit-address I2C target (slave). It sits next to a local processor that reaches it through a tiny register port. The block watches the bus for a START. It compares the following address byte against a programmed own address and answers with an ACK when the two agree and the block has been switched on. The direction bit then chooses one of two paths. On a write, incoming bytes are shifted in. On a read, bytes supplied by the processor are shifted out.

Each byte is paced by software. After a received byte, the block holds SCL low until the processor reads the data register, and the ACK for that byte is driven only then. On a read transfer, the block holds SCL low until the processor writes the next byte. A first-byte flag marks the byte that directly follows the address, which is typically a register pointer, so that software can tell it apart from the payload bytes after it. The open-drain pads are modelled as pull-low enables plus line inputs.

The register port uses single-cycle strobes. It has no back-pressure. A read or write strobe always completes in the cycle it is asserted, and read data is presented combinationally for that cycle. Flow control on the I2C side comes only from clock stretching.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: After reset, the own-address register reads 0, the status register reads 0, and neither SCL nor SDA is pulled low.
- R2: The own-address register (select 0) keeps 7 bits in bits 6:0, with bit 6 as the most significant address bit. Bit 7 reads 0 whatever was written.
- R3: An address byte whose upper 7 bits differ from the own address gets no ACK, and no status flag is raised.
- R4: When the enable bit (bit 0 of a write to select 1) is 0, even a matching address gets no ACK.
- R5: On a matching write address, the block ACKs. After each data byte, it sets the receive-pending flag (status bit 0), holds SCL low, and offers the byte at select 2.
- R6: The first-byte flag (status bit 2) is set together with the receive-pending flag only for the first byte after the address. A read of select 2 clears it.
- R7: A read of select 2 while a received byte is pending clears the receive-pending flag, releases SCL on the next clock, and makes the block drive the ACK for that byte. SDA changes only while SCL is low.
- R8: On a matching read address, the block sets the transmit-pending flag (status bit 1) and holds SCL low. A write to select 2 clears the flag, releases SCL, and the byte is sent MSB first.
- R9: When the controller ACKs a sent byte, the transmit-pending flag is raised again. When it NACKs, the transfer ends, no flag is raised, and SCL stays released.
- R10: A STOP returns the block to idle with both pending flags clear. The next transfer marks its first byte again.
- R11: A repeated START begins a new address phase, so a write of a pointer byte can be followed by a read without an intervening STOP.
- R12: The first-byte flag is never set during a transmit transfer.
- R13: A read of select 2 with no receive pending changes no flag and leaves SCL released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select: 0 own address, 1 control/status, 2 data |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle (has side effects on select 2) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| scl_i | input | 1 | SCL line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The hardest situations to reach are the ones where the bus is frozen by the block itself. The controller is stalled in the middle of a bit, and progress depends on a register access arriving from the other side. The bench therefore splits each byte at its stretch point. It first runs the controller model up to the clock edge where the target takes hold of SCL. It then checks the held line and the status flags, performs the processor access, and checks that SCL and the ACK appear one clock later. Only after that does it let the controller finish the bit. A repeated START from a write into a read, and a NACK on a sent byte, cover the flag transitions at the transfer boundaries.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int SEL_W    = 2;
  localparam logic [SEL_W-1:0] SEL_OWN  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_CS   = 2'd1;
  localparam logic [SEL_W-1:0] SEL_DATA = 2'd2;

  localparam int STAT_RX = 0;
  localparam int STAT_TX = 1;
  localparam int STAT_FB = 2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX_BITS,
    ST_RX_WAIT,
    ST_RX_ACK,
    ST_TX_WAIT,
    ST_TX_BITS,
    ST_TX_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = !scl_q && scl_s;
  assign scl_fall  = scl_q && !scl_s;
  assign start_det = scl_q && scl_s && sda_q && !sda_s;
  assign stop_det  = scl_q && scl_s && !sda_q && sda_s;
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             rx_req,
  input  logic             tx_req,
  input  logic             fbr,
  input  logic [DW-1:0]    rx_byte,
  output logic [AW-1:0]    own_addr,
  output logic             enable,
  output logic             host_rd_data,
  output logic             host_wr_data
);
  logic [DW-1:0] status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_addr <= '0;
      enable   <= 1'b0;
    end else if (reg_wr) begin
      if (reg_sel == SEL_OWN) own_addr <= reg_wdata[AW-1:0];
      if (reg_sel == SEL_CS)  enable   <= reg_wdata[0];
    end
  end

  always_comb begin
    status          = '0;
    status[STAT_RX] = rx_req;
    status[STAT_TX] = tx_req;
    status[STAT_FB] = fbr;
  end

  always_comb begin
    case (reg_sel)
      SEL_OWN:  reg_rdata = DW'(own_addr);
      SEL_CS:   reg_rdata = status;
      SEL_DATA: reg_rdata = rx_byte;
      default:  reg_rdata = '0;
    endcase
  end

  assign host_rd_data = reg_rd && (reg_sel == SEL_DATA);
  assign host_wr_data = reg_wr && (reg_sel == SEL_DATA);
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [AW-1:0] own_addr,
  input  logic          enable,
  input  logic          host_rd_data,
  input  logic          host_wr_data,
  input  logic [AW:0]   wdata,
  output logic [AW:0]   rx_byte,
  output logic          rx_req,
  output logic          tx_req,
  output logic          fbr,
  output logic          sda_oe
);
  localparam int BYTE_W = AW + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_RISE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(BYTE_W - 1);

  tgt_state_e        st;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              rw, first, ack_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sh      <= '0;
      cnt     <= '0;
      rw      <= 1'b0;
      first   <= 1'b0;
      ack_ok  <= 1'b0;
      rx_byte <= '0;
      rx_req  <= 1'b0;
      tx_req  <= 1'b0;
      fbr     <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_det || stop_det) begin
      st     <= start_det ? ST_ADDR : ST_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
      rx_req <= 1'b0;
      tx_req <= 1'b0;
      fbr    <= 1'b0;
    end else begin
      case (st)
        ST_ADDR: begin
          if (scl_rise) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == LAST_RISE) begin
            if (enable && sh[BYTE_W-1:1] == own_addr) begin
              sda_oe <= 1'b1;
              rw     <= sh[0];
              st     <= ST_ADDR_ACK;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            if (rw) begin
              tx_req <= 1'b1;
              st     <= ST_TX_WAIT;
            end else begin
              first <= 1'b1;
              st    <= ST_RX_BITS;
            end
          end
        end
        ST_RX_BITS: begin
          if (scl_rise) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == LAST_RISE) begin
            rx_byte <= sh;
            rx_req  <= 1'b1;
            fbr     <= first;
            first   <= 1'b0;
            st      <= ST_RX_WAIT;
          end
        end
        ST_RX_WAIT: begin
          if (host_rd_data) begin
            rx_req <= 1'b0;
            fbr    <= 1'b0;
            sda_oe <= 1'b1;
            st     <= ST_RX_ACK;
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= ST_RX_BITS;
          end
        end
        ST_TX_WAIT: begin
          if (host_wr_data) begin
            tx_req <= 1'b0;
            sh     <= wdata;
            sda_oe <= !wdata[BYTE_W-1];
            cnt    <= '0;
            st     <= ST_TX_BITS;
          end
        end
        ST_TX_BITS: begin
          if (scl_fall) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_FALL) begin
              sda_oe <= 1'b0;
              st     <= ST_TX_ACK;
            end else begin
              sh     <= {sh[BYTE_W-2:0], 1'b0};
              sda_oe <= !sh[BYTE_W-2];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            ack_ok <= !sda_s;
          end else if (scl_fall) begin
            if (ack_ok) begin
              tx_req <= 1'b1;
              st     <= ST_TX_WAIT;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_BITS   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_i,
  output logic       scl_oe,
  input  logic       sda_i,
  output logic       sda_oe
);
  localparam int DW = ADDR_BITS + 1;

  logic sda_s_w, scl_s_w, rise_w, fall_w, start_w, stop_w;
  logic [ADDR_BITS-1:0] own_w;
  logic enable_w, hrd_w, hwr_w;
  logic rx_req_w, tx_req_w, fbr_w;
  logic [DW-1:0] rx_byte_w;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s_w), .sda_s(sda_s_w), .scl_rise(rise_w), .scl_fall(fall_w),
    .start_det(start_w), .stop_det(stop_w)
  );

  i2c_tgt_regs #(.DW(DW), .AW(ADDR_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_req(rx_req_w), .tx_req(tx_req_w), .fbr(fbr_w), .rx_byte(rx_byte_w),
    .own_addr(own_w), .enable(enable_w), .host_rd_data(hrd_w),
    .host_wr_data(hwr_w)
  );

  i2c_tgt_engine #(.AW(ADDR_BITS)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s_w), .scl_rise(rise_w),
    .scl_fall(fall_w), .start_det(start_w), .stop_det(stop_w),
    .own_addr(own_w), .enable(enable_w), .host_rd_data(hrd_w),
    .host_wr_data(hwr_w), .wdata(reg_wdata), .rx_byte(rx_byte_w),
    .rx_req(rx_req_w), .tx_req(tx_req_w), .fbr(fbr_w), .sda_oe(sda_oe)
  );

  // Hold the clock low while software owes the block a data access.
  assign scl_oe = rx_req_w || tx_req_w;

  logic unused_w;
  assign unused_w = scl_s_w;
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk
  import i2c_tgt_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_sel,
  input logic       reg_rd,
  input logic       reg_wr,
  input logic       scl_i,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       rx_req,
  input logic       tx_req,
  input logic       fbr,
  input logic       stop_det
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_req && tx_req)); // R8

  AST_FBR_NEEDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    fbr |-> rx_req); // R6

  AST_FBR_NOT_TX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> !fbr); // R12

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i); // R7

  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_sel == SEL_DATA && rx_req) |=> (!rx_req && !fbr && !scl_oe && sda_oe)); // R7

  AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_DATA && tx_req) |=> (!tx_req && !scl_oe)); // R8

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!rx_req && !tx_req && !sda_oe)); // R10
endmodule

bind i2c_tgt_stretch i2c_tgt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd),
  .reg_wr(reg_wr), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .rx_req(rx_req_w), .tx_req(tx_req_w), .fbr(fbr_w), .stop_det(stop_w)
);

// File: tb/tb_i2c_tgt_stretch.sv
module tb_i2c_tgt_stretch;
  localparam int Q = 20;
  localparam logic [6:0] MY_ADDR = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] reg_sel = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic scl_oe, sda_oe;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_line, sda_line;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  assign scl_line = !(m_scl_low || scl_oe);
  assign sda_line = !(m_sda_low || sda_oe);

  i2c_tgt_stretch dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_i(scl_line), .scl_oe(scl_oe), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(posedge clk);
  endtask

  // ---------------- host side ----------------
  task automatic host_wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_rd = 1'b1;
    #2 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // ---------------- controller model ----------------
  task automatic wait_scl_high();
    int guard = 0;
    while (!scl_line && guard < 20000) begin
      @(posedge clk);
      guard++;
    end
  endtask

  task automatic m_start();
    m_sda_low = 1'b1; wait_q();
    m_scl_low = 1'b1; wait_q();
  endtask

  task automatic m_restart();
    m_sda_low = 1'b0; wait_q();
    m_scl_low = 1'b0; wait_scl_high(); wait_q();
    m_sda_low = 1'b1; wait_q();
    m_scl_low = 1'b1; wait_q();
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; wait_q();
    m_scl_low = 1'b0; wait_scl_high(); wait_q();
    m_sda_low = 1'b0; wait_q();
  endtask

  task automatic m_wbit(input logic b);
    m_sda_low = !b; wait_q();
    m_scl_low = 1'b0; wait_scl_high(); wait_q();
    m_scl_low = 1'b1; wait_q();
  endtask

  task automatic m_rbit(output logic b);
    m_sda_low = 1'b0; wait_q();
    m_scl_low = 1'b0; wait_scl_high();
    repeat (Q/2) @(posedge clk);
    b = sda_line;
    repeat (Q/2) @(posedge clk);
    m_scl_low = 1'b1; wait_q();
  endtask

  task automatic m_wbyte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) m_wbit(v[i]);
  endtask

  task automatic m_rbyte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) m_rbit(v[i]);
  endtask

  // Address phase with ACK collected; returns the ACK bit (0 = ACK).
  task automatic m_addr(input logic [6:0] a, input logic rd, output logic ack);
    m_wbyte({a, rd});
    m_rbit(ack);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [7:0] d;
    check(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
    host_rd(2'd0, d); check(d == 8'h00, "R1 own address", d, 0);
    host_rd(2'd1, d); check(d == 8'h00, "R1 status", d, 0);
  endtask

  task automatic t_own_addr();
    logic [7:0] d;
    host_wr(2'd0, 8'hFF);
    host_rd(2'd0, d); check(d == 8'h7F, "R2 upper bit reads 0", d, 8'h7F);
    host_wr(2'd0, {1'b0, MY_ADDR});
    host_rd(2'd0, d); check(d == {1'b0, MY_ADDR}, "R2 readback", d, MY_ADDR);
  endtask

  task automatic t_disabled();
    logic ack; logic [7:0] d;
    m_start(); m_addr(MY_ADDR, 1'b0, ack);
    check(ack == 1'b1, "R4 no ACK while disabled", ack, 1);
    host_rd(2'd1, d); check(d == 0, "R4 status", d, 0);
    m_stop();
  endtask

  task automatic t_mismatch();
    logic ack; logic [7:0] d;
    m_start(); m_addr(7'h15, 1'b0, ack);
    check(ack == 1'b1, "R3 no ACK on other address", ack, 1);
    host_rd(2'd1, d); check(d == 0, "R3 status", d, 0);
    check(!scl_oe, "R3 SCL released", scl_oe, 0);
    m_stop();
  endtask

  task automatic rx_one(input logic [7:0] v, input logic [7:0] exp_stat, input string tag);
    logic [7:0] d; logic ack;
    m_wbyte(v);
    host_rd(2'd1, d); check(d == exp_stat, tag, d, exp_stat);
    check(scl_oe == 1'b1, "R5 SCL held while byte pending", scl_oe, 1);
    host_rd(2'd2, d); check(d == v, "R5 received byte", d, v);
    // host_rd returns one full clock after the strobe edge
    check(!scl_oe && sda_oe, "R7 release and ACK after read", {scl_oe, sda_oe}, 1);
    host_rd(2'd1, d); check(d == 0, "R6 flags clear after read", d, 0);
    m_rbit(ack); check(ack == 1'b0, "R7 ACK seen by controller", ack, 0);
  endtask

  task automatic t_write_then_read();
    logic ack; logic [7:0] d, got;
    host_wr(2'd1, 8'h01);
    m_start(); m_addr(MY_ADDR, 1'b0, ack);
    check(ack == 1'b0, "R5 address ACK", ack, 0);
    rx_one(8'h5C, 8'b101, "R6 first byte flagged");
    rx_one(8'hA3, 8'b001, "R6 later byte unflagged");
    m_restart(); m_addr(MY_ADDR, 1'b1, ack);
    check(ack == 1'b0, "R11 ACK after repeated START", ack, 0);
    host_rd(2'd1, d); check(d == 8'b010, "R12 transmit pending, first-byte clear", d, 2);
    check(scl_oe == 1'b1, "R8 SCL held for transmit data", scl_oe, 1);
    host_wr(2'd2, 8'h96);
    check(!scl_oe, "R8 SCL released after write", scl_oe, 0);
    m_rbyte(got); check(got == 8'h96, "R8 byte sent MSB first", got, 8'h96);
    m_wbit(1'b0);
    host_rd(2'd1, d); check(d == 8'b010, "R9 new request after ACK", d, 2);
    host_wr(2'd2, 8'h3C);
    m_rbyte(got); check(got == 8'h3C, "R8 second byte", got, 8'h3C);
    m_wbit(1'b1);
    host_rd(2'd1, d); check(d == 0, "R9 no request after NACK", d, 0);
    check(!scl_oe && !sda_oe, "R9 lines released after NACK", {scl_oe, sda_oe}, 0);
    m_stop();
  endtask

  task automatic t_idle_read();
    logic [7:0] d;
    host_rd(2'd2, d);
    host_rd(2'd1, d); check(d == 0, "R13 idle data read changes no flag", d, 0);
    check(!scl_oe && !sda_oe, "R13 lines untouched", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_stop_restart();
    logic ack; logic [7:0] d;
    m_start(); m_addr(MY_ADDR, 1'b0, ack);
    rx_one(8'h11, 8'b101, "R6 first byte flagged");
    m_stop();
    host_rd(2'd1, d); check(d == 0, "R10 idle after STOP", d, 0);
    check(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
    m_start(); m_addr(MY_ADDR, 1'b0, ack);
    check(ack == 1'b0, "R10 new transfer ACKed", ack, 0);
    rx_one(8'hE7, 8'b101, "R10 first byte flagged again");
    m_stop();
  endtask

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    t_reset();
    t_own_addr();
    t_disabled();
    host_wr(2'd1, 8'h01);
    t_mismatch();
    t_write_then_read();
    t_idle_read();
    t_stop_restart();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule